// File: doc/BRIEF.md
# Two-Level Filtered Set-Associative Cache

This block is a small set-associative cache that avoids waking its way arrays whenever it can. Each accepted request is looked up in one cycle. In that cycle two filters work side by side on the registered address. The first is a single-entry buffer that holds the most recently delivered block. The second is a small partial-tag store holding a few low tag bits (the sentry bits) for every way of every set. A read that finds its block in the buffer is answered from the buffer, and no way is enabled. Otherwise only the ways whose sentry bits agree with the address are enabled, and the full comparison of the remaining tag runs on those ways alone.

When no enabled way holds the block, the cache fetches the whole block from lower memory over a simple request/acknowledge port. It places the block in a victim way picked per set in round-robin order and reloads the buffer with it. Writes go through to lower memory on a separate strobe. A write that hits updates the cached word, and also the buffer copy when the buffer holds that block. A write that misses does not allocate. Three counters report buffer hits, enabled ways summed over all lookups, and lookup misses.

With the default geometry the address splits into these fields: byte offset addr[1:0], word select addr[4:2], set index addr[7:5], sentry bits addr[9:8] (the two lowest tag bits) and remaining tag addr[31:10].

Top module: `cf_filtered_cache`

## Requirements
- R1: After reset, all cached blocks and the buffer are invalid and all three counters read zero. The first access after reset is therefore a miss that enables no way.
- R2: A read whose block address (addr[31:5]) equals the buffer's valid block address is answered from the buffer, with way_en all zero during its lookup cycle.
- R3: In the lookup cycle of any access that is not a buffer read hit, way_en bit w is 1 exactly when way w of the set addr[7:5] is valid and its stored sentry bits equal addr[9:8]. Writes never use the buffer filter.
- R4: A read with no enabled way holding the block is a miss. The cycle after lookup, mem_req rises with mem_addr equal to the request address with bits [4:0] cleared. It stays stable until mem_ack, and the response carries the requested word of mem_rdata.
- R5: When ways are enabled, a hit requires the stored remaining tag addr[31:10] to match as well. A sentry match with a different remaining tag is treated as a miss. On a hit, the response returns the word of the one matching way.
- R6: Every read hit (buffer or way) and every write raises rsp_valid for exactly one cycle. That cycle is the one right after the lookup cycle, which is itself the cycle after acceptance. req_ready is high only when the block is idle.
- R7: The word returned is word addr[4:2] of the block, with word 0 in block bits [31:0].
- R8: A refill into a set goes to the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping, on each refill into that set.
- R9: Every write emits a one-cycle wt_valid with wt_addr and wt_data equal to the request in the same cycle as its response. A write hit updates the cached word and the buffer copy. A write miss allocates nothing.
- R10: cnt_bb_hit counts buffer read hits. cnt_way_act adds the number of enabled ways of every lookup. cnt_miss counts lookups (read or write) with no hit.
- R11: After a refill or a way-array read hit, the buffer holds that block, so a read of the same block next is a buffer hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block is idle and takes a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| mem_req | output | 1 | Block refill request, held until mem_ack |
| mem_addr | output | 32 | Block-aligned refill address |
| mem_ack | input | 1 | Refill data valid |
| mem_rdata | input | 256 | Whole refilled block, word 0 in low bits |
| wt_valid | output | 1 | Write-through strobe |
| wt_addr | output | 32 | Write-through address |
| wt_data | output | 32 | Write-through data |
| way_en | output | 4 | Per-way enable during the lookup cycle |
| cnt_bb_hit | output | 16 | Buffer read hit count |
| cnt_way_act | output | 16 | Sum of enabled ways over lookups |
| cnt_miss | output | 16 | Lookup miss count |

## Verification
The bench keeps its own model of tags, sentry bits, valid bits, round-robin pointers and the buffer, and sweeps every set with several tags. In the lookup cycle of each access it predicts way_en and the outcome. The targeted corner cases are these. Four blocks sharing one sentry value in a set must enable all four ways, and a design that stopped at the first sentry match would return the wrong block. A fifth block in that set must evict by round robin, and a wrong victim turns a later expected hit into a miss. A read with no sentry match must request a refill at once. A buffer hit must leave way_en at zero and still respond in the same cycle as a way hit, and a design with a short path would respond early. Writes must refresh both the cached word and the buffer copy, and a stale buffer shows up as old data on the following buffer-hit read.

// File: rtl/cf_pkg.sv
// Shared types for the filtered cache.
// Assumes: nothing beyond IEEE 1800-2017.
package cf_pkg;

    // Control states: idle, one-cycle lookup, waiting for a refill.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } cf_state_e;

endpackage

// File: rtl/cf_block_buffer.sv
// Single-entry block buffer: holds one whole block and its block address.
// It compares the lookup block address combinationally and can take a one-word
// write for the block it holds.
// Assumes: load and word write are never requested in the same cycle.
module cf_block_buffer #(
    parameter int BADDR_W = 27,
    parameter int BLK_W   = 256,
    parameter int WORD_W  = 32,
    parameter int WSEL_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BADDR_W-1:0] look_baddr,
    input  logic               load,
    input  logic [BADDR_W-1:0] load_baddr,
    input  logic [BLK_W-1:0]   load_blk,
    input  logic               wr_en,
    input  logic [WSEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0]  wr_word,
    output logic               hit,
    output logic [BLK_W-1:0]   blk
);

    logic               vld_q;
    logic [BADDR_W-1:0] baddr_q;
    logic [BLK_W-1:0]   blk_q;

    // Match of the held block against the lookup address.
    assign hit = vld_q && (baddr_q == look_baddr);
    assign blk = blk_q;

    // Reload on refill or way hit; patch one word on a write to the held block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            baddr_q <= '0;
            blk_q   <= '0;
        end else if (load) begin
            vld_q   <= 1'b1;
            baddr_q <= load_baddr;
            blk_q   <= load_blk;
        end else if (wr_en && hit) begin
            blk_q[wr_sel*WORD_W +: WORD_W] <= wr_word;
        end
    end

    p_bb_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> vld_q && (baddr_q == $past(load_baddr)));

endmodule

// File: rtl/cf_sentry_filter.sv
// Partial-tag filter: per set and way, a valid bit plus a few low tag bits.
// It produces the vector of ways that could hold the looked-up block.
// Assumes: fill_set/fill_way name the refilled location in the fill cycle.
module cf_sentry_filter #(
    parameter int SETS     = 8,
    parameter int WAYS     = 4,
    parameter int IDX_W    = 3,
    parameter int WAY_IW   = 2,
    parameter int SENTRY_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_set,
    input  logic [SENTRY_W-1:0] rd_sentry,
    input  logic                fill_en,
    input  logic [IDX_W-1:0]    fill_set,
    input  logic [WAY_IW-1:0]   fill_way,
    input  logic [SENTRY_W-1:0] fill_sentry,
    output logic [WAYS-1:0]     match
);

    logic [WAYS-1:0]     vld_q [SETS];
    logic [SENTRY_W-1:0] sen_q [SETS][WAYS];

    // One comparator per way on the selected set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[rd_set][w] && (sen_q[rd_set][w] == rd_sentry);
    end

    // Valid bits: cleared by reset, set by refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (fill_en) begin
            vld_q[fill_set][fill_way] <= 1'b1;
        end
    end

    // Sentry bits: written by refill only.
    always_ff @(posedge clk) begin
        if (fill_en) sen_q[fill_set][fill_way] <= fill_sentry;
    end

    p_fill_marks_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_set)][$past(fill_way)]
                    && (sen_q[$past(fill_set)][$past(fill_way)] == $past(fill_sentry)));

endmodule

// File: rtl/cf_way_bank.sv
// One cache way: remaining-tag and data storage for every set.
// The read port is active only while en is high; otherwise its block output is
// zero and no hit is reported.
// Assumes: en is high only for valid entries (validity lives in the filter).
module cf_way_bank #(
    parameter int SETS   = 8,
    parameter int IDX_W  = 3,
    parameter int REST_W = 22,
    parameter int BLK_W  = 256,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              en,
    input  logic [IDX_W-1:0]  set,
    input  logic [REST_W-1:0] cmp_rest,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              fill_en,
    input  logic [REST_W-1:0] fill_rest,
    input  logic [BLK_W-1:0]  fill_blk,
    output logic              hit,
    output logic [BLK_W-1:0]  blk
);

    logic [REST_W-1:0] tag_q [SETS];
    logic [BLK_W-1:0]  blk_q [SETS];

    // Gated read and remaining-tag compare.
    assign hit = en && (tag_q[set] == cmp_rest);
    assign blk = en ? blk_q[set] : '0;

    // Whole-block refill, or single-word write-through update.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[set] <= fill_rest;
            blk_q[set] <= fill_blk;
        end else if (wr_en) begin
            blk_q[set][wr_sel*WORD_W +: WORD_W] <= wr_word;
        end
    end

endmodule

// File: rtl/cf_rr_victim.sv
// Per-set round-robin victim pointer.
// Assumes: adv pulses once per refill, with set naming the refilled set.
module cf_rr_victim #(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int IDX_W  = 3,
    parameter int WAY_IW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [IDX_W-1:0]  set,
    output logic [WAY_IW-1:0] victim
);

    logic [WAY_IW-1:0] ptr_q [SETS];

    assign victim = ptr_q[set];

    // Step the selected set's pointer with wrap at the last way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv) begin
            ptr_q[set] <= (ptr_q[set] == WAY_IW'(WAYS - 1)) ? '0 : ptr_q[set] + 1'b1;
        end
    end

    p_rr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (victim != WAY_IW'(WAYS - 1)) |=>
            ptr_q[$past(set)] == WAY_IW'($past(victim) + 1'b1));

    p_rr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (victim == WAY_IW'(WAYS - 1)) |=> ptr_q[$past(set)] == '0);

endmodule

// File: rtl/cf_filtered_cache.sv
// Set-associative cache with a two-stage access filter: a one-block buffer and
// a per-way sentry-bit filter are evaluated in parallel in the lookup cycle.
// Only sentry-matching ways are enabled, and misses refill whole blocks.
// Assumes: WAYS and SETS are powers of two >= 2, SENTRY_W < tag width,
// and lower memory eventually acknowledges every refill request.
module cf_filtered_cache
    import cf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int SETS        = 8,
    parameter int WAYS        = 4,
    parameter int SENTRY_W    = 2,
    parameter int CNT_W       = 16,
    localparam int WORD_W     = 8 * WORD_BYTES,
    localparam int WORDS      = BLOCK_BYTES / WORD_BYTES,
    localparam int BLK_W      = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rdata,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [WORD_W-1:0] wt_data,
    output logic [WAYS-1:0]   way_en,
    output logic [CNT_W-1:0]  cnt_bb_hit,
    output logic [CNT_W-1:0]  cnt_way_act,
    output logic [CNT_W-1:0]  cnt_miss
);

    localparam int BYTE_OFF = $clog2(WORD_BYTES);
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int OFF_W    = BYTE_OFF + WSEL_W;
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int REST_W   = TAG_W - SENTRY_W;
    localparam int BADDR_W  = ADDR_W - OFF_W;
    localparam int WAY_IW   = $clog2(WAYS);

    cf_state_e         state_q;
    logic              q_write;
    logic [ADDR_W-1:0] q_addr;
    logic [WORD_W-1:0] q_wdata;

    logic [WSEL_W-1:0]   q_widx;
    logic [IDX_W-1:0]    q_set;
    logic [SENTRY_W-1:0] q_sentry;
    logic [REST_W-1:0]   q_rest;
    logic [BADDR_W-1:0]  q_baddr;

    logic              look, fill_done;
    logic              bb_hit, bb_read_hit, hit_any, look_hit;
    logic [BLK_W-1:0]  bb_blk, hit_blk;
    logic [WAYS-1:0]   sen_match, way_hit, wr_word_en;
    logic [BLK_W-1:0]  bank_blk [WAYS];
    logic [WAY_IW-1:0] victim;

    // Field split of the registered request address.
    assign q_widx   = q_addr[OFF_W-1:BYTE_OFF];
    assign q_set    = q_addr[OFF_W +: IDX_W];
    assign q_sentry = q_addr[OFF_W+IDX_W +: SENTRY_W];
    assign q_rest   = q_addr[ADDR_W-1 -: REST_W];
    assign q_baddr  = q_addr[ADDR_W-1:OFF_W];

    assign look      = (state_q == ST_LOOK);
    assign fill_done = (state_q == ST_FILL) && mem_ack;

    // Selects one word from a block.
    function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] b,
                                                    input logic [WSEL_W-1:0] sel);
        pick_word = b[sel*WORD_W +: WORD_W];
    endfunction

    // First filter: the one-block buffer.
    cf_block_buffer #(
        .BADDR_W(BADDR_W), .BLK_W(BLK_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) u_bbuf (
        .clk(clk), .rst_n(rst_n),
        .look_baddr(q_baddr),
        .load((look && !q_write && !bb_hit && hit_any) || fill_done),
        .load_baddr(q_baddr),
        .load_blk(fill_done ? mem_rdata : hit_blk),
        .wr_en(look && q_write && hit_any),
        .wr_sel(q_widx),
        .wr_word(q_wdata),
        .hit(bb_hit),
        .blk(bb_blk)
    );

    // Second filter: sentry bits per way, evaluated alongside the buffer.
    cf_sentry_filter #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_IW(WAY_IW), .SENTRY_W(SENTRY_W)
    ) u_sentry (
        .clk(clk), .rst_n(rst_n),
        .rd_set(q_set), .rd_sentry(q_sentry),
        .fill_en(fill_done), .fill_set(q_set), .fill_way(victim),
        .fill_sentry(q_sentry),
        .match(sen_match)
    );

    cf_rr_victim #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_IW(WAY_IW)
    ) u_rr (
        .clk(clk), .rst_n(rst_n), .adv(fill_done), .set(q_set), .victim(victim)
    );

    // Way enables: nothing on a buffer read hit, otherwise the sentry matches.
    assign bb_read_hit = look && !q_write && bb_hit;
    assign way_en      = (look && !bb_read_hit) ? sen_match : '0;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign wr_word_en[w] = look && q_write && way_hit[w];
        cf_way_bank #(
            .SETS(SETS), .IDX_W(IDX_W), .REST_W(REST_W),
            .BLK_W(BLK_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
        ) u_bank (
            .clk(clk), .en(way_en[w]), .set(q_set), .cmp_rest(q_rest),
            .wr_en(wr_word_en[w]), .wr_sel(q_widx), .wr_word(q_wdata),
            .fill_en(fill_done && (victim == WAY_IW'(w))),
            .fill_rest(q_rest), .fill_blk(mem_rdata),
            .hit(way_hit[w]), .blk(bank_blk[w])
        );
    end

    // Merge the hitting way's block (at most one way hits).
    always_comb begin
        hit_blk = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) hit_blk = hit_blk | bank_blk[w];
        end
    end

    assign hit_any   = |way_hit;
    assign look_hit  = bb_read_hit || hit_any;
    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_FILL);
    assign mem_addr  = {q_baddr, {OFF_W{1'b0}}};

    // Control, response, write-through strobe and activity counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            q_write     <= 1'b0;
            q_addr      <= '0;
            q_wdata     <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            wt_valid    <= 1'b0;
            wt_addr     <= '0;
            wt_data     <= '0;
            cnt_bb_hit  <= '0;
            cnt_way_act <= '0;
            cnt_miss    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            wt_valid  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write <= req_write;
                        q_addr  <= req_addr;
                        q_wdata <= req_wdata;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    cnt_way_act <= cnt_way_act + CNT_W'($countones(way_en));
                    if (bb_read_hit) cnt_bb_hit <= cnt_bb_hit + 1'b1;
                    if (!look_hit)   cnt_miss   <= cnt_miss + 1'b1;
                    if (q_write) begin
                        wt_valid  <= 1'b1;
                        wt_addr   <= q_addr;
                        wt_data   <= q_wdata;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= '0;
                        state_q   <= ST_IDLE;
                    end else if (look_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= pick_word(bb_read_hit ? bb_blk : hit_blk, q_widx);
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q   <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= pick_word(mem_rdata, q_widx);
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_buf_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        look && !q_write && bb_hit |-> !hit_any);

    p_hit_single_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
        look |-> $onehot0(way_hit));

    p_nomatch_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        look && !q_write && !bb_hit && (sen_match == '0) |=> mem_req && !rsp_valid);

    p_refill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_fixed_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        look && (q_write || bb_hit || hit_any) |=> rsp_valid && req_ready);

    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sim_cf_filtered_cache.sv
// Self-checking bench: a reference model of tags, sentries, round robin and the
// buffer predicts way enables, outcome, data and counters for every access.
module sim_cf_filtered_cache;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write;
    logic [31:0]  req_addr, req_wdata;
    logic         req_ready, rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_ack;
    logic [255:0] mem_rdata;
    logic         wt_valid;
    logic [31:0]  wt_addr, wt_data;
    logic [3:0]   way_en;
    logic [15:0]  cnt_bb_hit, cnt_way_act, cnt_miss;

    int checks = 0;
    int failures = 0;

    // Reference model state.
    logic [21:0] m_rest [8][4];
    logic [1:0]  m_sen  [8][4];
    bit          m_vld  [8][4];
    int          m_rr   [8];
    bit          bb_v;
    logic [26:0] bb_b;
    int          e_bb, e_way, e_miss;
    logic [31:0] shadow [logic [31:0]];
    int          dly;

    always #10 clk = ~clk;   // 50 MHz

    cf_filtered_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data),
        .way_en(way_en),
        .cnt_bb_hit(cnt_bb_hit), .cnt_way_act(cnt_way_act), .cnt_miss(cnt_miss)
    );

    function automatic logic [31:0] mword(input logic [31:0] a);
        logic [31:0] k;
        k = {a[31:2], 2'b00};
        if (shadow.exists(k)) return shadow[k];
        return (k * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction

    function automatic logic [31:0] mk(input int rest, input int sen, input int st, input int w);
        return {22'(rest), 2'(sen), 3'(st), 3'(w), 2'b00};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Lower memory: answers a refill three cycles after it sees the request.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; dly = 0; mem_rdata = '0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (dly == 2) begin
                for (int i = 0; i < 8; i++)
                    mem_rdata[i*32 +: 32] = mword({mem_addr[31:5], 3'(i), 2'b00});
                mem_ack = 1'b1;
                dly = 0;
            end else begin
                dly++;
            end
        end
    end

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd);
        logic [2:0]  st;
        logic [1:0]  sn;
        logic [21:0] rs;
        logic [26:0] ba;
        logic [3:0]  emask;
        logic [31:0] exp_d;
        int          hw, v, n;
        bit          bbh;
        st = a[7:5]; sn = a[9:8]; rs = a[31:10]; ba = a[31:5];
        bbh = !wr && bb_v && (bb_b == ba);
        emask = '0; hw = -1;
        if (!bbh)
            for (int w = 0; w < 4; w++)
                if (m_vld[st][w] && m_sen[st][w] == sn) begin
                    emask[w] = 1'b1;
                    if (m_rest[st][w] == rs) hw = w;
                end
        @(negedge clk);
        chk(req_ready == 1'b1, "R6", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);                       // lookup cycle
        req_valid = 1'b0;
        chk(way_en == emask, bbh ? "R2" : "R3", "way enables", 64'(way_en), 64'(emask));
        chk(rsp_valid == 1'b0, "R6", "no response in lookup cycle", 64'(rsp_valid), 64'd0);
        @(negedge clk);                       // cycle after lookup
        e_way += $countones(emask);
        if (wr) begin
            chk(rsp_valid == 1'b1, "R6", "write response latency", 64'(rsp_valid), 64'd1);
            chk(wt_valid == 1'b1 && wt_addr == a && wt_data == wd, "R9", "write-through",
                {wt_addr, wt_data}, {a, wd});
            shadow[{a[31:2], 2'b00}] = wd;
            if (hw < 0) e_miss++;
        end else if (bbh || hw >= 0) begin
            exp_d = mword(a);
            chk(rsp_valid == 1'b1, "R6", "hit latency", 64'(rsp_valid), 64'd1);
            chk(rsp_rdata == exp_d, bbh ? "R2/R7" : "R5/R11", "hit data",
                64'(rsp_rdata), 64'(exp_d));
            if (bbh) e_bb++;
            else begin bb_v = 1'b1; bb_b = ba; end
        end else begin
            e_miss++;
            chk(mem_req == 1'b1 && mem_addr == {ba, 5'b0}, "R4", "refill request",
                64'(mem_addr), 64'({ba, 5'b0}));
            chk(rsp_valid == 1'b0, "R4", "no response before refill", 64'(rsp_valid), 64'd0);
            n = 0;
            while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
            exp_d = mword(a);
            chk(rsp_valid == 1'b1 && rsp_rdata == exp_d, "R4/R7", "refill data",
                64'(rsp_rdata), 64'(exp_d));
            v = m_rr[st];                      // R8 victim order
            m_vld[st][v] = 1'b1; m_sen[st][v] = sn; m_rest[st][v] = rs;
            m_rr[st] = (v + 1) % 4;
            bb_v = 1'b1; bb_b = ba;
        end
        chk(cnt_bb_hit == 16'(e_bb), "R10", "buffer hit count", 64'(cnt_bb_hit), 64'(e_bb));
        chk(cnt_way_act == 16'(e_way), "R10", "way activity count", 64'(cnt_way_act), 64'(e_way));
        chk(cnt_miss == 16'(e_miss), "R10", "miss count", 64'(cnt_miss), 64'(e_miss));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < 8; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_sen[s][w] = '0; m_rest[s][w] = '0; end
        end
        bb_v = 0; bb_b = '0; e_bb = 0; e_way = 0; e_miss = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1", "idle after reset",
            {req_ready, rsp_valid, mem_req}, 3'b100);
        chk(cnt_bb_hit == 0 && cnt_way_act == 0 && cnt_miss == 0, "R1", "counters cleared",
            {cnt_bb_hit, cnt_way_act, cnt_miss}, 0);
        chk(way_en == 4'b0 && wt_valid == 1'b0, "R1", "no way active", 64'(way_en), 64'd0);

        // R1: first access misses; then R2/R7 buffer hits on every word
        access(0, mk(5, 0, 0, 3), 0);
        for (int w = 0; w < 8; w++) access(0, mk(5, 0, 0, w), 0);

        // R3/R5/R11: distinct sentries in set 1, then a single-way hit and buffer reload
        for (int k = 0; k < 4; k++) access(0, mk(10 + k, k, 1, 0), 0);
        access(0, mk(10, 0, 1, 4), 0);
        access(0, mk(10, 0, 1, 6), 0);
        access(0, mk(12, 2, 1, 7), 0);

        // R5: shared sentry in set 2, all ways enabled; R8 round-robin eviction
        for (int k = 1; k <= 4; k++) access(0, mk(k, 1, 2, k), 0);
        access(0, mk(3, 1, 2, 0), 0);
        access(0, mk(5, 1, 2, 1), 0);
        access(0, mk(1, 1, 2, 2), 0);
        access(0, mk(2, 1, 2, 3), 0);
        access(0, mk(3, 1, 2, 5), 0);
        access(0, mk(4, 1, 2, 6), 0);

        // R4: no sentry match in set 2
        access(0, mk(9, 3, 2, 0), 0);

        // R9: write hit on buffered block, write hit on unbuffered block, write miss
        access(1, mk(9, 3, 2, 1), 32'hCAFE0001);
        access(0, mk(9, 3, 2, 1), 0);
        access(1, mk(10, 0, 1, 2), 32'hCAFE0002);
        access(0, mk(10, 0, 1, 2), 0);
        access(1, mk(77, 2, 5, 0), 32'hCAFE0003);
        access(0, mk(77, 2, 5, 0), 0);
        access(1, mk(77, 2, 5, 4), 32'hCAFE0004);
        access(0, mk(77, 2, 5, 4), 0);

        // Sweep of all sets with several tags, two passes with writes between
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 8; s++)
                for (int k = 0; k < 6; k++) begin
                    access(0, mk(k + 20, k % 4, s, (k + s + p) % 8), 0);
                    if (k == 2) access(1, mk(k + 20, k % 4, s, p), 32'hD000_0000 + 32'(s * 16 + p));
                end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule